// File: doc/BRIEF.md
# Slot-Zero Status Word Builder

This block assembles the 16-bit status word that a time-division framer places in slot 0 of every frame sent to an attached signal processor. The word gathers five kinds of information: per-stream input requests (an intercepted stream whose four-word stereo input buffer still has room asks for data), per-stream output-valid flags (which slot pairs of the frame carry data), two mailbox handshake flags, two sticky event flags, and fixed zero bits.

The word is captured on the clock edge that ends a frame-sync cycle. It then holds until the next frame-sync cycle, so the framer can shift it out serially without it changing. A 12-bit slot mask is captured in the same edge. It tells the framer which slots of the coming frame carry data. In modem mode, slot 2 is dropped from the mask because the modem uses it.

The status outputs have no flow-control handshake. The framer reads them whenever it needs them, and the block never waits for the framer. Streams are indexed 0 = serial port 0, 1 = serial port 1, 2 = FM synthesis, 3 = playback, 4 = capture.

Top module: `tdm_status_word_gen`

## Requirements
- R1: While rst_n is low, status_word and slot_mask are all zeros.
- R2: Bits 13 and 5 of status_word are always 0.
- R3: Bit i (0..4) of the captured word is 1 exactly when intercept_en[i] is 1 and occ[i] is below 4 in the frame-sync cycle.
- R4: Bit 8+i of the captured word is 1 exactly when out_strobe[i] was high in at least one cycle from the previous frame-sync cycle (inclusive) to the current one (exclusive). After reset, the count starts at reset release.
- R5: Bit 6 (mailbox 0) and bit 7 (mailbox 1) are 1 when the latest access to that mailbox before the frame-sync cycle was a write, and 0 when it was a read. A write and a read in the same cycle count as a write.
- R6: Bit 15 (power-down) is set by a pdn_evt pulse and stays set until it is cleared.
- R7: A clr_req pulse clears both bit 15 and bit 14 (plug-and-play, set by pnp_evt). An event in the same cycle as clr_req keeps its bit set. Only state from before the frame-sync cycle reaches the word.
- R8: status_word and slot_mask change only on the edge that ends a frame-sync cycle.
- R9: In slot_mask, bit 0 is 1 and bit 1 is 0 after the first capture. For stream i, bits 10-2i and 11-2i follow that stream's captured valid bit.
- R10: When modem_mode is high in the frame-sync cycle, slot_mask bit 2 is 0. Bit 3 still follows the capture valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_sync | input | 1 | One-cycle marker; the word is captured on the edge that ends this cycle |
| intercept_en | input | 5 | Per-stream intercept enable |
| occ | input | 5x3 | Per-stream input-buffer occupancy, in words |
| out_strobe | input | 5 | Per-stream pulse: output data produced for the current frame |
| mbx_wr | input | 2 | Mailbox write strobes |
| mbx_rd | input | 2 | Mailbox read strobes |
| pdn_evt | input | 1 | Power-down event pulse |
| pnp_evt | input | 1 | Plug-and-play event pulse |
| clr_req | input | 1 | Clear request from the incoming control word |
| modem_mode | input | 1 | Modem mode; slot 2 is not used for capture |
| status_word | output | 16 | Captured slot-0 word |
| slot_mask | output | 12 | Captured per-slot data-present mask |

## Verification
Both outputs are due one rising edge after a frame-sync cycle. Request levels are taken from the sync cycle itself. Mailbox, sticky and valid state is taken from the cycles before it, so an access during the sync cycle shows up only one frame later. The bench steps a behavioural model on every rising edge and compares each field on the next falling edge. Frame periods run from one cycle upward, and directed collisions (set with clear, write with read, strobe in the sync cycle) land on the exact edges where these cycle rules matter.

// File: rtl/tdm_status_pkg.sv
package tdm_status_pkg;
  localparam int NSTR    = 5;
  localparam int NMBX    = 2;
  localparam int NEVT    = 2;
  localparam int WORD_W  = 16;
  localparam int NSLOT   = 12;
  localparam int REQ_LSB = 0;
  localparam int RSV_LO  = 5;
  localparam int MBX_LSB = 6;
  localparam int VLD_LSB = 8;
  localparam int RSV_HI  = 13;
  localparam int PNP_BIT = 14;
  localparam int PDN_BIT = 15;
  localparam int EVT_PNP = 0;
  localparam int EVT_PDN = 1;

  typedef enum logic [2:0] {
    STR_SER0 = 3'd0,
    STR_SER1 = 3'd1,
    STR_FM   = 3'd2,
    STR_PLAY = 3'd3,
    STR_CAP  = 3'd4
  } stream_e;
endpackage

// File: rtl/tdm_req_flags.sv
module tdm_req_flags #(
  parameter int NSTR       = 5,
  parameter int FIFO_DEPTH = 4,
  parameter int OCC_W      = 3
) (
  input  logic [NSTR-1:0]            intercept_en,
  input  logic [NSTR-1:0][OCC_W-1:0] occ,
  output logic [NSTR-1:0]            req
);
  localparam logic [OCC_W-1:0] FULL_LVL = OCC_W'(FIFO_DEPTH);

  for (genvar i = 0; i < NSTR; i++) begin : g_req
    // room left in the stereo input buffer and the stream is intercepted
    assign req[i] = intercept_en[i] & (occ[i] < FULL_LVL);
  end
endmodule

// File: rtl/tdm_mbx_flags.sv
module tdm_mbx_flags #(
  parameter int NMBX = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NMBX-1:0] wr,
  input  logic [NMBX-1:0] rd,
  output logic [NMBX-1:0] q
);
  for (genvar k = 0; k < NMBX; k++) begin : g_mbx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[k] <= 1'b0;
      else if (wr[k]) q[k] <= 1'b1;
      else if (rd[k]) q[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_sticky_evt.sv
module tdm_sticky_evt #(
  parameter int NEVT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] set,
  input  logic            clr,
  output logic [NEVT-1:0] q
);
  for (genvar e = 0; e < NEVT; e++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[e] <= 1'b0;
      else if (set[e]) q[e] <= 1'b1;
      else if (clr)    q[e] <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_valid_accum.sv
module tdm_valid_accum #(
  parameter int NSTR = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_sync,
  input  logic [NSTR-1:0] strobe,
  output logic [NSTR-1:0] acc
);
  // a strobe in the sync cycle belongs to the frame that starts there
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc <= '0;
    else if (frame_sync) acc <= strobe;
    else                 acc <= acc | strobe;
  end
endmodule

// File: rtl/tdm_status_word_gen.sv
module tdm_status_word_gen
  import tdm_status_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int OCC_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_sync,
  input  logic [NSTR-1:0]            intercept_en,
  input  logic [NSTR-1:0][OCC_W-1:0] occ,
  input  logic [NSTR-1:0]            out_strobe,
  input  logic [NMBX-1:0]            mbx_wr,
  input  logic [NMBX-1:0]            mbx_rd,
  input  logic                       pdn_evt,
  input  logic                       pnp_evt,
  input  logic                       clr_req,
  input  logic                       modem_mode,
  output logic [WORD_W-1:0]          status_word,
  output logic [NSLOT-1:0]           slot_mask
);
  logic [NSTR-1:0]   req;
  logic [NSTR-1:0]   vld_acc;
  logic [NMBX-1:0]   mbx_q;
  logic [NEVT-1:0]   sticky_q;
  logic [NEVT-1:0]   evt_set;
  logic [WORD_W-1:0] word_next;
  logic [NSLOT-1:0]  mask_next;
  logic [NSTR-1:0]   vld_next;

  assign evt_set[EVT_PDN] = pdn_evt;
  assign evt_set[EVT_PNP] = pnp_evt;

  tdm_req_flags #(.NSTR(NSTR), .FIFO_DEPTH(FIFO_DEPTH), .OCC_W(OCC_W)) u_req (
    .intercept_en(intercept_en),
    .occ         (occ),
    .req         (req)
  );

  tdm_valid_accum #(.NSTR(NSTR)) u_vld (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_sync(frame_sync),
    .strobe    (out_strobe),
    .acc       (vld_acc)
  );

  tdm_mbx_flags #(.NMBX(NMBX)) u_mbx (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (mbx_wr),
    .rd   (mbx_rd),
    .q    (mbx_q)
  );

  tdm_sticky_evt #(.NEVT(NEVT)) u_evt (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (evt_set),
    .clr  (clr_req),
    .q    (sticky_q)
  );

  always_comb begin
    word_next                     = '0;
    word_next[PDN_BIT]            = sticky_q[EVT_PDN];
    word_next[PNP_BIT]            = sticky_q[EVT_PNP];
    word_next[VLD_LSB +: NSTR]    = vld_acc;
    word_next[MBX_LSB +: NMBX]    = mbx_q;
    word_next[REQ_LSB +: NSTR]    = req;
  end

  assign vld_next     = word_next[VLD_LSB +: NSTR];
  assign mask_next[0] = 1'b1;
  assign mask_next[1] = 1'b0;

  for (genvar i = 0; i < NSTR; i++) begin : g_slot
    localparam int HI = NSLOT - 1 - 2 * i;
    localparam int LO = HI - 1;
    assign mask_next[HI] = vld_next[i];
    if (i == int'(STR_CAP)) begin : g_cap
      assign mask_next[LO] = vld_next[i] & ~modem_mode;
    end else begin : g_plain
      assign mask_next[LO] = vld_next[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_word <= '0;
      slot_mask   <= '0;
    end else if (frame_sync) begin
      status_word <= word_next;
      slot_mask   <= mask_next;
    end
  end
endmodule

// File: rtl/tdm_status_chk.sv
module tdm_status_chk
  import tdm_status_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int OCC_W      = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       frame_sync,
  input logic [NSTR-1:0]            intercept_en,
  input logic [NSTR-1:0][OCC_W-1:0] occ,
  input logic [NMBX-1:0]            mbx_wr,
  input logic [NMBX-1:0]            mbx_rd,
  input logic                       pdn_evt,
  input logic                       pnp_evt,
  input logic                       clr_req,
  input logic                       modem_mode,
  input logic [NMBX-1:0]            mbx_q,
  input logic [NEVT-1:0]            sticky_q,
  input logic [WORD_W-1:0]          status_word,
  input logic [NSLOT-1:0]           slot_mask
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_zero_chk: assert (status_word == '0 && slot_mask == '0);
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[RSV_HI] == 1'b0 && status_word[RSV_LO] == 1'b0);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(status_word) && $stable(slot_mask));

  for (genvar i = 0; i < NSTR; i++) begin : g_req_chk
    // R3
    req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |=> status_word[REQ_LSB + i] ==
        $past(intercept_en[i] && (occ[i] < OCC_W'(FIFO_DEPTH))));
  end

  for (genvar k = 0; k < NMBX; k++) begin : g_mbx_chk
    // R5
    mbx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mbx_wr[k] |=> mbx_q[k]);
    // R5
    mbx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mbx_rd[k] && !mbx_wr[k] |=> !mbx_q[k]);
  end

  // R6
  pdn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_evt |=> sticky_q[EVT_PDN]);

  // R7
  pnp_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pnp_evt |=> sticky_q[EVT_PNP]);

  // R7
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !pdn_evt && !pnp_evt |=> sticky_q == '0);

  // R10
  modem_slot2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync && modem_mode |=> !slot_mask[2]);
endmodule

bind tdm_status_word_gen tdm_status_chk #(.FIFO_DEPTH(FIFO_DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_sync  (frame_sync),
  .intercept_en(intercept_en),
  .occ         (occ),
  .mbx_wr      (mbx_wr),
  .mbx_rd      (mbx_rd),
  .pdn_evt     (pdn_evt),
  .pnp_evt     (pnp_evt),
  .clr_req     (clr_req),
  .modem_mode  (modem_mode),
  .mbx_q       (mbx_q),
  .sticky_q    (sticky_q),
  .status_word (status_word),
  .slot_mask   (slot_mask)
);

// File: tb/tdm_status_word_gen_tb_top.sv
`timescale 1ns/1ps
module tdm_status_word_gen_tb_top;
  localparam int DEPTH = 4;
  localparam int OW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0;
  logic [4:0] intercept_en = '0;
  logic [4:0][OW-1:0] occ = '0;
  logic [4:0] out_strobe = '0;
  logic [1:0] mbx_wr = '0, mbx_rd = '0;
  logic pdn_evt = 1'b0, pnp_evt = 1'b0, clr_req = 1'b0, modem_mode = 1'b0;
  logic [15:0] status_word;
  logic [11:0] slot_mask;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  tdm_status_word_gen #(.FIFO_DEPTH(DEPTH), .OCC_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .intercept_en(intercept_en),
    .occ(occ), .out_strobe(out_strobe), .mbx_wr(mbx_wr), .mbx_rd(mbx_rd),
    .pdn_evt(pdn_evt), .pnp_evt(pnp_evt), .clr_req(clr_req), .modem_mode(modem_mode),
    .status_word(status_word), .slot_mask(slot_mask)
  );

  // behavioural reference state
  int m_pdn, m_pnp;
  int m_mbx[2];
  int m_vacc[5];
  int m_word, m_mask;

  task automatic check(string tag, int got, int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pdn = 0; m_pnp = 0; m_mbx[0] = 0; m_mbx[1] = 0;
      foreach (m_vacc[i]) m_vacc[i] = 0;
      m_word = 0; m_mask = 0;
    end else begin
      if (frame_sync) begin
        int w, msk;
        w = m_pdn * 32768 + m_pnp * 16384 + m_mbx[1] * 128 + m_mbx[0] * 64;
        msk = 1;
        for (int i = 0; i < 5; i++) begin
          if (intercept_en[i] && int'(occ[i]) < DEPTH) w += (1 << i);
          if (m_vacc[i] != 0) begin
            w += (1 << (8 + i));
            msk += (1 << (11 - 2 * i));
            if (!(i == 4 && modem_mode)) msk += (1 << (10 - 2 * i));
          end
        end
        m_word = w; m_mask = msk;
      end
      for (int i = 0; i < 5; i++) begin
        if (frame_sync) m_vacc[i] = int'(out_strobe[i]);
        else if (out_strobe[i]) m_vacc[i] = 1;
      end
      for (int k = 0; k < 2; k++) begin
        if (mbx_wr[k]) m_mbx[k] = 1;
        else if (mbx_rd[k]) m_mbx[k] = 0;
      end
      if (pdn_evt) m_pdn = 1; else if (clr_req) m_pdn = 0;
      if (pnp_evt) m_pnp = 1; else if (clr_req) m_pnp = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 reserved", {status_word[13], status_word[5]}, 0);
      check("R3 request", status_word[4:0], m_word & 31);
      check("R4 valid-out", status_word[12:8], (m_word >> 8) & 31);
      check("R5 mailbox", status_word[7:6], (m_word >> 6) & 3);
      check("R6 power-down", status_word[15], (m_word >> 15) & 1);
      check("R7 plug-and-play", status_word[14], (m_word >> 14) & 1);
      check("R8 whole word", status_word, m_word);
      check("R9 slot mask", {slot_mask[11:3], slot_mask[1:0]},
            ((m_mask >> 3) << 2) | (m_mask & 3));
      check("R10 slot 2", slot_mask[2], (m_mask >> 2) & 1);
    end
  end

  task automatic idle();
    @(negedge clk);
    frame_sync = 0; out_strobe = '0; mbx_wr = '0; mbx_rd = '0;
    pdn_evt = 0; pnp_evt = 0; clr_req = 0;
  endtask

  task automatic sync_pulse();
    @(negedge clk);
    frame_sync = 1; out_strobe = '0; mbx_wr = '0; mbx_rd = '0;
    pdn_evt = 0; pnp_evt = 0; clr_req = 0;
  endtask

  task automatic rand_phase(int cycles, int period);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      frame_sync   = (c % period) == 0;
      intercept_en = 5'($urandom);
      for (int i = 0; i < 5; i++) occ[i] = OW'($urandom);
      out_strobe   = 5'($urandom) & 5'($urandom);
      mbx_wr       = 2'($urandom) & 2'($urandom);
      mbx_rd       = 2'($urandom) & 2'($urandom);
      pdn_evt      = ($urandom % 16) == 0;
      pnp_evt      = ($urandom % 16) == 0;
      clr_req      = ($urandom % 8) == 0;
      modem_mode   = ($urandom % 3) == 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset word", status_word, 0);
    check("R1 reset mask", slot_mask, 0);
    @(negedge clk);
    rst_n = 1;
    // first capture with nothing happened yet
    sync_pulse();
    idle();
    check("R9 first capture bit0", slot_mask[1:0], 1);
    // set and clear in the same cycle: set wins (R7)
    @(negedge clk); pdn_evt = 1; clr_req = 1;
    idle();
    sync_pulse();
    idle();
    check("R7 set beats clear", status_word[15], 1);
    // clear alone, in the sync cycle: not seen until the next frame (R7)
    @(negedge clk); frame_sync = 1; clr_req = 1;
    idle();
    check("R7 clear late", status_word[15], 1);
    sync_pulse();
    idle();
    check("R7 cleared", status_word[15], 0);
    // write and read together on mailbox 1 count as write (R5)
    @(negedge clk); mbx_wr = 2'b10; mbx_rd = 2'b10;
    sync_pulse();
    idle();
    check("R5 wr+rd", status_word[7], 1);
    // strobe in the sync cycle counts for the next frame (R4)
    @(negedge clk); frame_sync = 1; out_strobe = 5'b10000; modem_mode = 1;
    sync_pulse(); modem_mode = 1;
    idle();
    check("R4 strobe next frame", status_word[12], 1);
    check("R10 modem drops slot 2", slot_mask[3:2], 2'b10);
    // request boundary: occupancy 3 asks, 4 does not (R3)
    @(negedge clk); frame_sync = 1; intercept_en = 5'b00011; occ[0] = 3; occ[1] = 4;
    idle();
    check("R3 occupancy boundary", status_word[1:0], 2'b01);
    rand_phase(1500, 1);
    rand_phase(1500, 3);
    rand_phase(1500, 12);
    rand_phase(1000, 37);
    idle();
    idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule